// File: doc/BRIEF.md
# Per-Sector Write Lock Controller

This block holds the write-protection state of every erase sector of a flash array and rules on each program or erase request before it reaches the array. Two protection tiers are kept for each sector. A soft lock is set and cleared by command. A hard lock can be set by command but is removed only by reset. Together with a write-protect input pin, these bits decide whether a sector may be written.

Lock commands carry a sector index and an operation. Each command changes only the sector it names. A program or erase request is answered one clock later with either a grant or a protect error. A combinational query port returns the 3-bit state of any sector and whether it is writable at that moment. The array has 16 small sectors and 254 large sectors (270 in total, index 0 to 269). Every sector is locked on its own, and both sizes are handled the same way.

Top module: `sector_write_guard`

## Requirements
- R1: While `rstN` is low and after it rises, every sector holds soft lock = 1 and hard lock = 0, `qryWritable` is 0 for every sector, and `reqGrant` and `protErr` are 0.
- R2: Operation code 2'b10 (soft unlock) clears the soft bit of the addressed sector, and code 2'b01 (soft lock) sets it. The new state is visible on the query port right after the clock edge that samples the command.
- R3: Operation code 2'b11 (hard lock) sets the hard bit. No command clears it. Only a low `rstN` returns it to 0.
- R4: `qryState` is {wpActive, hard, soft}: bit 2 follows the `wpActive` pin, bit 1 is the hard lock and bit 0 is the soft lock. The fully unlocked state reads 3'b000.
- R5: A sector is writable exactly when its soft bit is 0 and it is not the case that both its hard bit and `wpActive` are 1.
- R6: A soft unlock has no effect on a sector whose hard bit is 1 while `wpActive` is 1. With `wpActive` at 0, the soft unlock takes effect even on a hard-locked sector.
- R7: A command changes only the state of the sector it addresses. All other sectors keep their state.
- R8: One cycle after `reqValid` is sampled, exactly one of `reqGrant` and `protErr` is 1 for one cycle. `reqGrant` is chosen when the sector was writable in the sampling cycle, using the state before any command sampled in that same cycle. Without a request, both outputs are 0.
- R9: A sector index of 270 or above is out of range. Commands to it are ignored, requests to it get `protErr`, and a query of it returns `qryWritable` = 0.
- R10: Operation code 2'b00 is a no-operation and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wpActive | input | 1 | Write-protect pin, 1 = protection asserted |
| cmdOp | input | 2 | Lock operation: 00 none, 01 soft lock, 10 soft unlock, 11 hard lock |
| cmdSector | input | 9 | Sector addressed by the lock operation |
| reqValid | input | 1 | Program or erase request strobe |
| reqSector | input | 9 | Sector targeted by the request |
| reqGrant | output | 1 | Request permitted, one cycle after the request |
| protErr | output | 1 | Request rejected (protect error), one cycle after the request |
| qrySector | input | 9 | Sector to query |
| qryState | output | 3 | {wpActive, hard, soft} of the queried sector |
| qryWritable | output | 1 | Queried sector is writable now |

## Verification
There are two kinds of result, and each is due at a different time. The query outputs are combinational, so the bench checks them at a falling edge one nanosecond after setting `qrySector`; this is the first falling edge after the rising edge that applied the command. Request responses come from a register. The driver tags each expected grant or error with the cycle after the sampling edge, and the monitor compares the outputs at the falling edge of exactly that cycle. In every other cycle the monitor expects both response outputs to be low. Requests that arrive in the same cycle as a command to the same sector are predicted from the state before that command.

// File: rtl/sector_lock_pkg.sv
`timescale 1ns/1ps
package sector_lock_pkg;

  typedef enum logic [1:0] {
    OP_NOP         = 2'b00,
    OP_SOFT_LOCK   = 2'b01,
    OP_SOFT_UNLOCK = 2'b10,
    OP_HARD_LOCK   = 2'b11
  } lockOp_t;

  // strobes from control to the lock-bit datapath
  typedef struct packed {
    logic setSoft;
    logic clrSoft;
    logic setHard;
  } lockStb_t;

endpackage

// File: rtl/sector_lock_ctrl.sv
`timescale 1ns/1ps
module sector_lock_ctrl
  import sector_lock_pkg::*;
#(
  parameter int NUM_SECT = 270,
  parameter int IDX_W    = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cmdOp,
  input  logic [IDX_W-1:0] cmdSector,
  input  logic             wpActive,
  input  logic             cmdHard,
  input  logic             reqValid,
  input  logic             reqWritable,
  output lockStb_t         stb,
  output logic             reqGrant,
  output logic             protErr
);

  lockOp_t op;
  logic    cmdInRange;

  assign op         = lockOp_t'(cmdOp);
  assign cmdInRange = ({1'b0, cmdSector} < (IDX_W+1)'(NUM_SECT));

  always_comb begin
    stb = '0;
    if (cmdInRange) begin
      case (op)
        OP_SOFT_LOCK:   stb.setSoft = 1'b1;
        OP_SOFT_UNLOCK: stb.clrSoft = !(cmdHard && wpActive);
        OP_HARD_LOCK:   stb.setHard = 1'b1;
        default:        stb = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqGrant <= 1'b0;
      protErr  <= 1'b0;
    end else begin
      reqGrant <= reqValid && reqWritable;
      protErr  <= reqValid && !reqWritable;
    end
  end

  AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(reqGrant && protErr)); // R8
  AST_RESP_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (reqGrant || protErr)); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !(reqGrant || protErr)); // R8

endmodule

// File: rtl/sector_lock_datapath.sv
`timescale 1ns/1ps
module sector_lock_datapath
  import sector_lock_pkg::*;
#(
  parameter int NUM_SECT = 270,
  parameter int IDX_W    = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  lockStb_t         stb,
  input  logic [IDX_W-1:0] cmdSector,
  input  logic             wpActive,
  input  logic [IDX_W-1:0] reqSector,
  input  logic [IDX_W-1:0] qrySector,
  output logic             cmdHard,
  output logic             reqWritable,
  output logic [2:0]       qryState,
  output logic             qryWritable
);

  logic [NUM_SECT-1:0] softVec;
  logic [NUM_SECT-1:0] hardVec;

  for (genvar g = 0; g < NUM_SECT; g++) begin : gSector
    logic softBit;
    logic hardBit;
    logic hit;

    assign hit = (cmdSector == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        softBit <= 1'b1;
        hardBit <= 1'b0;
      end else begin
        if (hit && stb.setSoft)      softBit <= 1'b1;
        else if (hit && stb.clrSoft) softBit <= 1'b0;
        if (hit && stb.setHard)      hardBit <= 1'b1;
      end
    end

    assign softVec[g] = softBit;
    assign hardVec[g] = hardBit;

    AST_HARD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      hardBit |=> hardBit); // R3
    AST_SOFT_HELD: assert property (@(posedge clk) disable iff (!rstN)
      (hardBit && wpActive && softBit) |=> softBit); // R6
  end

  function automatic logic inRange(input logic [IDX_W-1:0] idx);
    return ({1'b0, idx} < (IDX_W+1)'(NUM_SECT));
  endfunction

  function automatic logic canWrite(input logic [IDX_W-1:0] idx);
    if (!inRange(idx)) return 1'b0;
    return !softVec[idx] && !(hardVec[idx] && wpActive);
  endfunction

  assign cmdHard     = inRange(cmdSector) ? hardVec[cmdSector] : 1'b0;
  assign reqWritable = canWrite(reqSector);
  assign qryWritable = canWrite(qrySector);
  assign qryState    = inRange(qrySector)
                     ? {wpActive, hardVec[qrySector], softVec[qrySector]}
                     : {wpActive, 2'b00};

  AST_STB_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setSoft || stb.clrSoft || stb.setHard) |-> inRange(cmdSector)); // R9
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.setSoft, stb.clrSoft, stb.setHard})); // R10

endmodule

// File: rtl/sector_write_guard.sv
`timescale 1ns/1ps
module sector_write_guard
  import sector_lock_pkg::*;
#(
  parameter int  NUM_SMALL = 16,
  parameter int  NUM_LARGE = 254,
  localparam int NUM_SECT  = NUM_SMALL + NUM_LARGE,
  localparam int IDX_W     = $clog2(NUM_SECT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wpActive,
  input  logic [1:0]       cmdOp,
  input  logic [IDX_W-1:0] cmdSector,
  input  logic             reqValid,
  input  logic [IDX_W-1:0] reqSector,
  output logic             reqGrant,
  output logic             protErr,
  input  logic [IDX_W-1:0] qrySector,
  output logic [2:0]       qryState,
  output logic             qryWritable
);

  lockStb_t stb;
  logic     cmdHard;
  logic     reqWritable;

  sector_lock_ctrl #(.NUM_SECT(NUM_SECT), .IDX_W(IDX_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdOp      (cmdOp),
    .cmdSector  (cmdSector),
    .wpActive   (wpActive),
    .cmdHard    (cmdHard),
    .reqValid   (reqValid),
    .reqWritable(reqWritable),
    .stb        (stb),
    .reqGrant   (reqGrant),
    .protErr    (protErr)
  );

  sector_lock_datapath #(.NUM_SECT(NUM_SECT), .IDX_W(IDX_W)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cmdSector  (cmdSector),
    .wpActive   (wpActive),
    .reqSector  (reqSector),
    .qrySector  (qrySector),
    .cmdHard    (cmdHard),
    .reqWritable(reqWritable),
    .qryState   (qryState),
    .qryWritable(qryWritable)
  );

endmodule

// File: tb/test_sector_write_guard.sv
`timescale 1ns/1ps
module test_sector_write_guard;

  localparam int NUM = 270;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wpActive = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic [8:0] cmdSector = '0;
  logic       reqValid = 1'b0;
  logic [8:0] reqSector = '0;
  logic [8:0] qrySector = '0;
  logic       reqGrant, protErr, qryWritable;
  logic [2:0] qryState;

  sector_write_guard i_sector_write_guard (
    .clk(clk), .rstN(rstN), .wpActive(wpActive), .cmdOp(cmdOp),
    .cmdSector(cmdSector), .reqValid(reqValid), .reqSector(reqSector),
    .reqGrant(reqGrant), .protErr(protErr), .qrySector(qrySector),
    .qryState(qryState), .qryWritable(qryWritable)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic  grant;
    logic  err;
    int    due;
    string tag;
  } respItem_t;
  respItem_t sb[$];

  bit mSoft[NUM];
  bit mHard[NUM];

  function automatic bit mWritable(int s);
    if (s >= NUM) return 0;
    return !mSoft[s] && !(mHard[s] && wpActive);
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NUM; i++) begin
      mSoft[i] = 1;
      mHard[i] = 0;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops scoreboard items when they are due
  always @(negedge clk) begin
    if (rstN) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        respItem_t it;
        it = sb.pop_front();
        checks++;
        if (reqGrant !== it.grant || protErr !== it.err) begin
          failures++;
          $display("FAIL %s grant/err=%b%b expected %b%b", it.tag, reqGrant, protErr, it.grant, it.err);
        end
      end else if (reqGrant || protErr) begin
        checks++;
        failures++;
        $display("FAIL R8 response without request grant/err=%b%b expected 00", reqGrant, protErr);
      end
    end
  end

  // driver: one cycle with an optional command and an optional request
  task automatic drive(input logic [1:0] op, input int cs, input bit rv, input int rs, input string tag);
    @(negedge clk);
    cmdOp = op; cmdSector = 9'(cs); reqValid = rv; reqSector = 9'(rs);
    if (rv) sb.push_back('{mWritable(rs), !mWritable(rs), cyc + 1, tag});
    @(posedge clk);
    if (cs < NUM) begin
      case (op)
        2'b01: mSoft[cs] = 1;
        2'b10: if (!(mHard[cs] && wpActive)) mSoft[cs] = 0;
        2'b11: mHard[cs] = 1;
        default: ;
      endcase
    end
    #1;
    cmdOp = 2'b00; reqValid = 1'b0;
  endtask

  task automatic chk(input int s, input string tag);
    logic [2:0] expState;
    @(negedge clk);
    qrySector = 9'(s);
    #1;
    checks++;
    if (s < NUM) begin
      expState = {wpActive, mHard[s], mSoft[s]};
      if (qryState !== expState || qryWritable !== mWritable(s)) begin
        failures++;
        $display("FAIL %s sector %0d state/wr=%b/%b expected %b/%b", tag, s, qryState, qryWritable, expState, mWritable(s));
      end
    end else if (qryWritable !== 1'b0) begin
      failures++;
      $display("FAIL %s sector %0d wr=%b expected 0", tag, s, qryWritable);
    end
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk(0, "R1"); chk(15, "R1"); chk(16, "R1"); chk(269, "R1");
    drive(2'b00, 0, 1, 5, "R1 request after reset");
    // R2 soft unlock/lock, R7 neighbours untouched
    drive(2'b10, 5, 0, 0, "R2");
    chk(5, "R2 unlock"); chk(4, "R7"); chk(6, "R7");
    drive(2'b00, 0, 1, 5, "R8 grant");
    drive(2'b01, 5, 0, 0, "R2");
    chk(5, "R2 lock");
    // R4 R5 with hard lock
    drive(2'b10, 20, 0, 0, "R2");
    drive(2'b11, 20, 0, 0, "R3");
    chk(20, "R5 hard wp low");
    wpActive = 1'b1;
    chk(20, "R4 R5 hard wp high");
    drive(2'b00, 0, 1, 20, "R5 request blocked");
    // R6 unlock ignored while hard && wp
    drive(2'b01, 20, 0, 0, "R6");
    drive(2'b10, 20, 0, 0, "R6");
    chk(20, "R6 unlock ignored");
    wpActive = 1'b0;
    drive(2'b10, 20, 0, 0, "R6");
    chk(20, "R6 unlock with wp low");
    // R3 nothing clears hard
    drive(2'b01, 20, 0, 0, "R3");
    drive(2'b10, 20, 0, 0, "R3");
    chk(20, "R3 hard survives");
    // R10 nop
    drive(2'b10, 7, 0, 0, "R2");
    drive(2'b00, 7, 0, 0, "R10");
    chk(7, "R10 nop");
    // R9 out of range
    drive(2'b10, 300, 0, 0, "R9");
    chk(44, "R9 no alias"); chk(300, "R9 query");
    drive(2'b00, 0, 1, 300, "R9 request");
    // R8 command and request in the same cycle
    drive(2'b10, 8, 1, 8, "R8 same-cycle uses old state");
    drive(2'b00, 0, 1, 8, "R8 grant after unlock");
    // R2 all small sectors
    for (int i = 0; i < 16; i++) drive(2'b10, i, 0, 0, "R2");
    for (int i = 0; i < 16; i++) chk(i, "R2 small sectors");
    chk(16, "R7 large untouched");
    // R3 R1 reset clears hard
    @(negedge clk); rstN = 1'b0;
    modelReset();
    chk(20, "R1 in reset");
    @(negedge clk); rstN = 1'b1;
    chk(20, "R3 reset clears hard"); chk(3, "R1 after reset");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule